// File: doc/BRIEF.md
# Serial Gain Register Interface

This block is the digital control port of a multi-channel volume stage. A host shifts 8-bit words into it over a four-pin serial bus made of a serial clock, a data line, an active-low write enable and an active-low load strobe. The top bit of each word marks its kind. An address word picks one of seven targets: six channel gain registers and one master attenuation register. The data words that follow in the same write frame give the selected target its new level. Received levels wait in a staging bank. They appear on the parallel outputs only when a load happens.

Two load modes exist. In four-wire mode a falling edge on the load pin commits the staging bank. In three-wire mode the host ties load to write, the load pin is ignored, and the return of write to high commits the bank. After reset every output reads zero and every mute flag is set. A register's mute flag clears at the first commit after that register has received a data word.

All bus pins are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are found in the system clock domain. The serial clock may idle at either level, because only its falling edge samples data.

Top module: `gain_serial_port`

## Requirements
- R1: Words are 8 bits, shifted most significant bit first. Each bit is the data line value at a falling edge of the serial clock, whether that clock idles high or low between frames.
- R2: Serial clock edges while write is high shift nothing and change no staged or output value.
- R3: A word with bit 7 = 1 is an address word. Its bits 2:0 select the target: 0 to 5 select channels 0 to 5, and 6 selects the master. Bits 6:3 are ignored. The value 7 deselects, so data words that follow are discarded until the next valid address word.
- R4: A word with bit 7 = 0 is a data word for the selected target. The master takes bits 6:0. A channel takes bits 4:0 and ignores bits 6:5. When several data words reach the same target, the last one wins.
- R5: With three_wire_i = 0, outputs change only on a high-to-low transition of ld_n_i. That transition copies the whole staging bank to master_o and chan_o (channel k at bits [5k+4:5k]).
- R6: With three_wire_i = 1, ld_n_i is ignored and a low-to-high transition of wr_n_i performs the commit.
- R7: After reset master_o and chan_o are zero and mute_o is all ones. Bit k of mute_o belongs to channel k and bit 6 to the master.
- R8: A mute bit clears at the first commit after its register received a data word. It never sets again until reset.
- R9: Write going high clears the bit counter and discards a partial trailing word. It also ends the address selection, so a data word at the start of the next frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_n_i | input | 1 | Active-low write enable framing the serial words |
| ld_n_i | input | 1 | Active-low load strobe (four-wire mode) |
| three_wire_i | input | 1 | 1 selects three-wire mode (commit on write release) |
| master_o | output | 7 | Active master attenuation level |
| chan_o | output | 30 | Active channel gain levels, 5 bits per channel |
| mute_o | output | 7 | Mute flags: bits 5:0 channels, bit 6 master |

## Verification
Directed frames cover each word kind separately. One frame has a channel data word with bits 6:5 set, which tells a correct 5-bit channel field from a wider one. A frame carries several data words to the master, which separates last-wins from first-wins. Another frame starts with address 7, which shows whether an invalid selection leaks data into the previous target. A 5-bit partial word followed by a fresh frame exposes a bit counter that is not cleared. A data word at the start of a frame exposes a selection that survives across frames. Random frames then mix both clock idle levels, both load modes, random upper address bits and occasional partial words, and every output and mute flag is compared against a bench model after each commit.

// File: rtl/gsp_pkg.sv
`timescale 1ns/1ps
package gsp_pkg;
    localparam int WORD_W = 8;

    typedef struct packed {
        logic data;
        logic sclk;
        logic wr_n;
        logic ld_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{data: 1'b0, sclk: 1'b1, wr_n: 1'b1, ld_n: 1'b1};
endpackage

// File: rtl/gsp_sync.sv
`timescale 1ns/1ps
module gsp_sync
    import gsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output pins_t pins_o
);
    typedef struct packed {
        pins_t s1;
        pins_t s2;
    } sync_st_t;

    sync_st_t q, d;

    always_comb begin
        d.s1 = pins_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: PINS_IDLE, s2: PINS_IDLE};
        else        q <= d;
    end

    assign pins_o = q.s2;
endmodule

// File: rtl/gsp_shift.sv
`timescale 1ns/1ps
module gsp_shift
    import gsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pins_t             pins_s,
    output logic              byte_v_o,
    output logic [WORD_W-1:0] byte_o,
    output logic              frame_end_o
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              sclk_p;
        logic              wr_p;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              byte_v;
        logic              frame_end;
    } shift_st_t;

    shift_st_t q, d;

    always_comb begin
        d           = q;
        d.sclk_p    = pins_s.sclk;
        d.wr_p      = pins_s.wr_n;
        d.byte_v    = 1'b0;
        d.frame_end = pins_s.wr_n & ~q.wr_p;
        if (pins_s.wr_n) begin
            d.cnt = '0;
        end else if (q.sclk_p && !pins_s.sclk) begin
            d.sh     = {q.sh[WORD_W-2:0], pins_s.data};
            d.cnt    = q.cnt + 1'b1;
            d.byte_v = (q.cnt == CNT_W'(WORD_W - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.sclk_p <= PINS_IDLE.sclk;
            q.wr_p   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_v_o    = q.byte_v;
    assign byte_o      = q.sh;
    assign frame_end_o = q.frame_end;
endmodule

// File: rtl/gsp_regs.sv
`timescale 1ns/1ps
module gsp_regs
    import gsp_pkg::*;
#(
    parameter int NCH = 6,
    parameter int MW  = 7,
    parameter int CW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_s,
    input  logic              three_wire,
    input  logic              byte_v,
    input  logic [WORD_W-1:0] byte_i,
    input  logic              frame_end,
    output logic [MW-1:0]     master_o,
    output logic [NCH*CW-1:0] chan_o,
    output logic [NCH:0]      mute_o,
    output logic              commit_o
);
    localparam int AW = $clog2(NCH + 1);

    typedef struct packed {
        logic              ld_p;
        logic [AW-1:0]     sel;
        logic              sel_ok;
        logic [MW-1:0]     stg_m;
        logic [NCH*CW-1:0] stg_c;
        logic [NCH:0]      wrt;
        logic [MW-1:0]     act_m;
        logic [NCH*CW-1:0] act_c;
        logic [NCH:0]      mute;
    } regs_st_t;

    regs_st_t q, d;
    logic     commit;

    always_comb begin
        commit = three_wire ? frame_end : (q.ld_p & ~ld_s);

        d      = q;
        d.ld_p = ld_s;

        if (byte_v) begin
            if (byte_i[WORD_W-1]) begin
                d.sel    = byte_i[AW-1:0];
                d.sel_ok = (byte_i[AW-1:0] <= AW'(NCH));
            end else if (q.sel_ok) begin
                if (q.sel == AW'(NCH)) begin
                    d.stg_m    = byte_i[MW-1:0];
                    d.wrt[NCH] = 1'b1;
                end
                for (int k = 0; k < NCH; k++) begin
                    if (q.sel == AW'(k)) begin
                        d.stg_c[k*CW +: CW] = byte_i[CW-1:0];
                        d.wrt[k]            = 1'b1;
                    end
                end
            end
        end

        if (frame_end) d.sel_ok = 1'b0;

        if (commit) begin
            d.act_m = q.stg_m;
            d.act_c = q.stg_c;
            d.mute  = q.mute & ~q.wrt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ld_p <= 1'b1;
            q.mute <= '1;
        end else begin
            q <= d;
        end
    end

    assign master_o = q.act_m;
    assign chan_o   = q.act_c;
    assign mute_o   = q.mute;
    assign commit_o = commit;
endmodule

// File: rtl/gain_serial_port.sv
`timescale 1ns/1ps
module gain_serial_port
    import gsp_pkg::*;
#(
    parameter int NCH = 6,
    parameter int MW  = 7,
    parameter int CW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              wr_n_i,
    input  logic              ld_n_i,
    input  logic              three_wire_i,
    output logic [MW-1:0]     master_o,
    output logic [NCH*CW-1:0] chan_o,
    output logic [NCH:0]      mute_o
);
    pins_t             pins_a;
    pins_t             pins_s;
    logic              wr_s;
    logic              byte_v;
    logic [WORD_W-1:0] byte_w;
    logic              frame_end;
    logic              commit;

    assign pins_a = '{data: sdata_i, sclk: sclk_i, wr_n: wr_n_i, ld_n: ld_n_i};
    assign wr_s   = pins_s.wr_n;

    gsp_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_a),
        .pins_o (pins_s)
    );

    gsp_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_s      (pins_s),
        .byte_v_o    (byte_v),
        .byte_o      (byte_w),
        .frame_end_o (frame_end)
    );

    gsp_regs #(.NCH(NCH), .MW(MW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_s       (pins_s.ld_n),
        .three_wire (three_wire_i),
        .byte_v     (byte_v),
        .byte_i     (byte_w),
        .frame_end  (frame_end),
        .master_o   (master_o),
        .chan_o     (chan_o),
        .mute_o     (mute_o),
        .commit_o   (commit)
    );
endmodule

// File: rtl/gsp_chk.sv
`timescale 1ns/1ps
module gsp_chk #(
    parameter int NCH = 6,
    parameter int MW  = 7,
    parameter int CW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_s,
    input logic              byte_v,
    input logic              commit,
    input logic [MW-1:0]     master_o,
    input logic [NCH*CW-1:0] chan_o,
    input logic [NCH:0]      mute_o
);
    // R2: no word completes while write has been high for two cycles
    p_no_byte_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && $past(wr_s)) |-> !byte_v);

    // R5: active levels hold unless a commit happened
    p_hold_without_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(master_o) && $stable(chan_o)));

    // R8: a mute flag never rises after reset
    p_mute_never_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mute_o & ~$past(mute_o)) == '0));

    // R8: a mute flag only changes right after a commit
    p_unmute_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_o != $past(mute_o)) |-> $past(commit));
endmodule

bind gain_serial_port gsp_chk #(.NCH(NCH), .MW(MW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_s     (wr_s),
    .byte_v   (byte_v),
    .commit   (commit),
    .master_o (master_o),
    .chan_o   (chan_o),
    .mute_o   (mute_o)
);

// File: tb/gain_serial_port_bench.sv
`timescale 1ns/1ps
module gain_serial_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        wr_n_i = 1'b1;
    logic        ld_n_i = 1'b1;
    logic        three_wire_i = 1'b0;
    logic [6:0]  master_o;
    logic [29:0] chan_o;
    logic [6:0]  mute_o;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;

    // bench model
    logic [6:0] m_sm, m_am;
    logic [4:0] m_sc[6];
    logic [4:0] m_ac[6];
    logic [6:0] m_wrt, m_mute;
    logic [2:0] m_sel;
    bit         m_ok;

    always #4 clk = ~clk;

    gain_serial_port u_gain_serial_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk_i),
        .sdata_i      (sdata_i),
        .wr_n_i       (wr_n_i),
        .ld_n_i       (ld_n_i),
        .three_wire_i (three_wire_i),
        .master_o     (master_o),
        .chan_o       (chan_o),
        .mute_o       (mute_o)
    );

    function automatic logic [6:0] exp_master();
        return m_am;
    endfunction

    function automatic logic [4:0] exp_chan(int k);
        return m_ac[k];
    endfunction

    task automatic model_reset();
        m_sm = '0; m_am = '0; m_wrt = '0; m_mute = '1; m_sel = '0; m_ok = 0;
        for (int k = 0; k < 6; k++) begin m_sc[k] = '0; m_ac[k] = '0; end
    endtask

    task automatic model_byte(logic [7:0] b);
        if (b[7]) begin
            m_sel = b[2:0];
            m_ok  = (b[2:0] <= 3'd6);
        end else if (m_ok) begin
            if (m_sel == 3'd6) m_sm = b[6:0];
            else               m_sc[m_sel] = b[4:0];
            m_wrt[m_sel] = 1'b1;
        end
    endtask

    task automatic model_commit();
        m_am = m_sm;
        for (int k = 0; k < 6; k++) m_ac[k] = m_sc[k];
        m_mute = m_mute & ~m_wrt;
    endtask

    task automatic gap();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "master", int'(master_o), int'(exp_master()));
        for (int k = 0; k < 6; k++)
            chk(req, $sformatf("chan%0d", k), int'(chan_o[k*5 +: 5]), int'(exp_chan(k)));
        chk(req, "mute", int'(mute_o), int'(m_mute));
    endtask

    // one falling serial clock edge per bit, idle level given
    task automatic send_bits(logic [7:0] val, int nbits, bit idle_hi);
        for (int i = 0; i < nbits; i++) begin
            sdata_i = val[7-i];
            gap();
            sclk_i = ~idle_hi;
            gap();
            sclk_i = idle_hi;
            gap();
        end
    endtask

    task automatic send_byte(logic [7:0] b, bit idle_hi);
        send_bits(b, 8, idle_hi);
        model_byte(b);
    endtask

    task automatic begin_frame(bit idle_hi);
        sclk_i = idle_hi;
        gap();
        wr_n_i = 1'b0;
        if (three_wire_i) ld_n_i = 1'b0;
        gap();
    endtask

    task automatic end_frame();
        wr_n_i = 1'b1;
        if (three_wire_i) ld_n_i = 1'b1;
        gap();
        gap();
        m_ok = 0;
        if (three_wire_i) model_commit();
    endtask

    task automatic load4();
        ld_n_i = 1'b0;
        gap();
        ld_n_i = 1'b1;
        gap();
        model_commit();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nerr++;
            nchecks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        gap();
        check_all("R7 reset");

        // R1 R4: channel 2, idle-low clock, staged only
        begin_frame(1'b0);
        send_byte(8'h82, 1'b0);
        send_byte(8'h15, 1'b0);
        end_frame();
        check_all("R5 before load");
        load4();
        check_all("R4 R8 chan2 load");

        // R1 idle-high clock, R4 last word wins on master, channel ignores bits 6:5
        begin_frame(1'b1);
        send_byte(8'h86, 1'b1);
        send_byte(8'h2A, 1'b1);
        send_byte(8'h7F, 1'b1);
        send_byte(8'hF9, 1'b1);   // upper address bits ignored: channel 1
        send_byte(8'h6B, 1'b1);
        end_frame();
        load4();
        check_all("R1 R4 master last wins");

        // R3: invalid address 7 discards data; valid address afterwards works
        begin_frame(1'b0);
        send_byte(8'h87, 1'b0);
        send_byte(8'h11, 1'b0);
        send_byte(8'h83, 1'b0);
        send_byte(8'h09, 1'b0);
        end_frame();
        load4();
        check_all("R3 invalid address");

        // R2: clock activity while write is high changes nothing
        for (int i = 0; i < 8; i++) begin
            sdata_i = i[0];
            gap();
            sclk_i = 1'b1;
            gap();
            sclk_i = 1'b0;
            gap();
        end
        load4();
        check_all("R2 write high ignored");

        // R9: partial word discarded, selection ends with frame
        begin_frame(1'b0);
        send_byte(8'h84, 1'b0);
        send_byte(8'h0C, 1'b0);
        send_bits(8'hFF, 5, 1'b0);
        end_frame();
        begin_frame(1'b0);
        send_byte(8'h05, 1'b0);
        end_frame();
        begin_frame(1'b0);
        send_byte(8'h85, 1'b0);
        send_byte(8'h1E, 1'b0);
        end_frame();
        load4();
        check_all("R9 partial word");

        // R6: three-wire mode commits on write release only
        three_wire_i = 1'b1;
        gap();
        begin_frame(1'b1);
        send_byte(8'h80, 1'b1);
        send_byte(8'h07, 1'b1);
        check_all("R6 mid frame no commit");
        end_frame();
        check_all("R6 commit on write release");

        // random frames in both modes and both idle levels
        for (int it = 0; it < 120; it++) begin
            bit idle_hi;
            int nb;
            three_wire_i = 1'($urandom_range(0, 1));
            gap();
            idle_hi = 1'($urandom_range(0, 1));
            nb = $urandom_range(1, 4);
            begin_frame(idle_hi);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] w;
                if (b == 0 || $urandom_range(0, 9) < 3)
                    w = {1'b1, 4'($urandom), 3'($urandom_range(0, 7))};
                else
                    w = {1'b0, 7'($urandom)};
                send_byte(w, idle_hi);
            end
            if ($urandom_range(0, 9) == 0)
                send_bits(8'($urandom), $urandom_range(1, 7), idle_hi);
            end_frame();
            if (!three_wire_i) load4();
            check_all("R4 R5 R6 R8 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end
endmodule